// File: doc/BRIEF.md
# Break-Reply Baud Rate Detector

This block finds the bit period of a serial target whose rate is not known in advance. When started, it pulls the shared line low for a fixed break interval and then releases it. The target answers with its own low interval followed by a 0x55 sync character. The block times the first high data bit of that reply, which runs from a rising edge to the next falling edge, against a cycle counter. From the measured width it derives the divisor that a UART sampling at eight clocks per bit would need.

The line input passes through a two-flop synchronizer and a majority-free glitch filter. The filter accepts a new level only after a run of identical samples, so short spikes never reach the edge timer. If the counter wraps before both edges have been seen, the block reports an error with zeroed results. A good measurement is followed by a second break, which checks the link again. Only after that break does the block signal completion.

Top module: `baud_probe`

## Requirements
- R1: After synchronous reset, `brk_o`, `done_o` and `err_o` are 0, and `width_o` and `div_o` are 0.
- R2: A `start_i` pulse while idle asserts `brk_o` (1 means pull the line low) for exactly `BREAK_CYCLES` consecutive cycles.
- R3: If the `CNT_W`-bit counter, cleared when the released line is seen high, wraps before the falling edge is captured, the block ends with `err_o` = 1, `width_o` = 0 and `div_o` = 0.
- R4: On success, `width_o` equals the number of clock cycles the line spent high in the first high pulse after the line is seen high following the break. This is the pulse that follows the first low interval.
- R5: `div_o` equals floor((`width_o` - 4) / 8), or 0 when `width_o` is below 4.
- R6: A level on the line that lasts fewer than `FILT_LEN` (default 4) consecutive cycles is ignored and does not change the measured width.
- R7: After a successful measurement, a confirmation break of exactly `BREAK_CYCLES` cycles is driven before completion is signalled, and `err_o` stays 0.
- R8: `done_o` is high for a single cycle at the end of each run. `width_o`, `div_o` and `err_o` hold after it and are cleared by the next accepted start.
- R9: A `start_i` pulse while a run is in progress is ignored, and the run completes with the result of the original run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, accepted only while idle |
| line_i | input | 1 | Raw serial line level (asynchronous) |
| brk_o | output | 1 | 1 = drive the line low (break) |
| width_o | output | CNT_W | Measured high-bit width in cycles |
| div_o | output | CNT_W | Derived UART divisor |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Detection error (counter wrapped) |

## Verification
The assertions assume that the line is back high once a break is released. This means every break run ends cleanly and is followed by a measurement phase before any further break. They also assume that `start_i` is sampled only on clock edges. The stimulus models the target to meet these assumptions. It holds the line high through every break, waits a few cycles after release, and then drives a low interval, a high bit and a trailing low. It adds deliberate short spikes only inside the low or high intervals, never at their edges. The wrap cases come from stretching either interval past the counter range rather than from reversing the reply order.

// File: rtl/baud_probe_pkg.sv
package baud_probe_pkg;

    localparam int DIV_OFFSET = 4;
    localparam int DIV_SHIFT  = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BREAK,
        ST_SETTLE,
        ST_RISE,
        ST_FALL,
        ST_CONFIRM
    } bp_state_e;

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } bp_line_t;

    function automatic logic [31:0] bp_divisor(input logic [31:0] w);
        if (w < 32'(DIV_OFFSET))
            return 32'd0;
        return (w - 32'(DIV_OFFSET)) >> DIV_SHIFT;
    endfunction

endpackage

// File: rtl/baud_probe_filter.sv
module baud_probe_filter
    import baud_probe_pkg::*;
#(
    parameter int FILT_LEN = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     line_i,
    output bp_line_t ev_o
);
    logic                sync1_q, sync2_q;
    logic [FILT_LEN-1:0] hist_q;
    logic                level_q, level_d_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q   <= 1'b1;
            sync2_q   <= 1'b1;
            hist_q    <= '1;
            level_q   <= 1'b1;
            level_d_q <= 1'b1;
        end else begin
            sync1_q   <= line_i;
            sync2_q   <= sync1_q;
            hist_q    <= {hist_q[FILT_LEN-2:0], sync2_q};
            level_d_q <= level_q;
            if (&hist_q)
                level_q <= 1'b1;
            else if (~|hist_q)
                level_q <= 1'b0;
        end
    end

    assign ev_o.level = level_q;
    assign ev_o.rise  = level_q & ~level_d_q;
    assign ev_o.fall  = ~level_q & level_d_q;

endmodule

// File: rtl/baud_probe_timer.sv
module baud_probe_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o
);
    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_o <= '0;
            ovf_o <= 1'b0;
        end else begin
            cnt_o <= cnt_o + 1'b1;
            if (&cnt_o)
                ovf_o <= 1'b1;
        end
    end
endmodule

// File: rtl/baud_probe_ctrl.sv
module baud_probe_ctrl
    import baud_probe_pkg::*;
#(
    parameter int CNT_W        = 16,
    parameter int BREAK_CYCLES = 3000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  bp_line_t         ev_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             ovf_i,
    output logic             clr_o,
    output logic             brk_o,
    output logic [CNT_W-1:0] width_o,
    output logic [CNT_W-1:0] div_o,
    output logic             done_o,
    output logic             err_o
);
    localparam int            BC_W    = $clog2(BREAK_CYCLES + 1);
    localparam logic [BC_W-1:0] BC_LAST = BC_W'(BREAK_CYCLES - 1);

    bp_state_e        state_q;
    logic [BC_W-1:0]  bcnt_q;
    logic [CNT_W-1:0] cap_q;
    logic [CNT_W-1:0] span;

    assign span  = cnt_i - cap_q;
    assign clr_o = (state_q == ST_SETTLE) && ev_i.level;
    assign brk_o = (state_q == ST_BREAK) || (state_q == ST_CONFIRM);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            bcnt_q  <= '0;
            cap_q   <= '0;
            width_o <= '0;
            div_o   <= '0;
            done_o  <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_BREAK;
                        bcnt_q  <= '0;
                        width_o <= '0;
                        div_o   <= '0;
                        err_o   <= 1'b0;
                    end
                end
                ST_BREAK: begin
                    if (bcnt_q == BC_LAST) begin
                        state_q <= ST_SETTLE;
                        bcnt_q  <= '0;
                    end else begin
                        bcnt_q <= bcnt_q + 1'b1;
                    end
                end
                ST_SETTLE: begin
                    if (ev_i.level)
                        state_q <= ST_RISE;
                end
                ST_RISE, ST_FALL: begin
                    if (ovf_i) begin
                        state_q <= ST_IDLE;
                        done_o  <= 1'b1;
                        err_o   <= 1'b1;
                        width_o <= '0;
                        div_o   <= '0;
                    end else if (state_q == ST_RISE && ev_i.rise) begin
                        cap_q   <= cnt_i;
                        state_q <= ST_FALL;
                    end else if (state_q == ST_FALL && ev_i.fall) begin
                        width_o <= span;
                        div_o   <= CNT_W'(bp_divisor(32'(span)));
                        bcnt_q  <= '0;
                        state_q <= ST_CONFIRM;
                    end
                end
                ST_CONFIRM: begin
                    if (bcnt_q == BC_LAST) begin
                        state_q <= ST_IDLE;
                        bcnt_q  <= '0;
                        done_o  <= 1'b1;
                    end else begin
                        bcnt_q <= bcnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/baud_probe.sv
module baud_probe
    import baud_probe_pkg::*;
#(
    parameter int CNT_W        = 16,
    parameter int BREAK_CYCLES = 3000,
    parameter int FILT_LEN     = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             line_i,
    output logic             brk_o,
    output logic [CNT_W-1:0] width_o,
    output logic [CNT_W-1:0] div_o,
    output logic             done_o,
    output logic             err_o
);
    bp_line_t         ev;
    logic [CNT_W-1:0] cnt;
    logic             ovf;
    logic             clr;

    baud_probe_filter #(.FILT_LEN(FILT_LEN)) filt_i (
        .clk    (clk),
        .rst    (rst),
        .line_i (line_i),
        .ev_o   (ev)
    );

    baud_probe_timer #(.CNT_W(CNT_W)) tmr_i (
        .clk   (clk),
        .rst   (rst),
        .clr_i (clr),
        .cnt_o (cnt),
        .ovf_o (ovf)
    );

    baud_probe_ctrl #(.CNT_W(CNT_W), .BREAK_CYCLES(BREAK_CYCLES)) ctrl_i (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .ev_i    (ev),
        .cnt_i   (cnt),
        .ovf_i   (ovf),
        .clr_o   (clr),
        .brk_o   (brk_o),
        .width_o (width_o),
        .div_o   (div_o),
        .done_o  (done_o),
        .err_o   (err_o)
    );
endmodule

// File: rtl/baud_probe_chk.sv
module baud_probe_chk #(
    parameter int CNT_W        = 16,
    parameter int BREAK_CYCLES = 3000
) (
    input logic             clk,
    input logic             rst,
    input logic             brk_o,
    input logic [CNT_W-1:0] width_o,
    input logic [CNT_W-1:0] div_o,
    input logic             done_o,
    input logic             err_o
);
    int run_q;

    always_ff @(posedge clk) begin
        if (rst)
            run_q <= 0;
        else if (brk_o)
            run_q <= run_q + 1;
        else
            run_q <= 0;
    end

    // R1
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (!brk_o && !done_o && !err_o && width_o == '0 && div_o == '0));

    // R2 / R7: every break is exactly BREAK_CYCLES long
    assert_break_len_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(brk_o) |-> run_q == BREAK_CYCLES);

    assert_break_bound_R7: assert property (@(posedge clk) disable iff (rst)
        brk_o |-> run_q < BREAK_CYCLES);

    // R3
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        err_o |-> (width_o == '0 && div_o == '0));

    assert_err_at_done_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(err_o) |-> done_o);

    // R8
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_hold_after_done_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> ($stable(width_o) && $stable(div_o) && $stable(err_o)));

    assert_no_break_at_done_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !brk_o);
endmodule

bind baud_probe baud_probe_chk #(.CNT_W(CNT_W), .BREAK_CYCLES(BREAK_CYCLES)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .brk_o   (brk_o),
    .width_o (width_o),
    .div_o   (div_o),
    .done_o  (done_o),
    .err_o   (err_o)
);

// File: tb/baud_probe_tb_top.sv
module baud_probe_tb_top;
    localparam int CW = 10;
    localparam int BC = 50;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic          line_i = 1'b1;
    logic          brk_o;
    logic [CW-1:0] width_o;
    logic [CW-1:0] div_o;
    logic          done_o;
    logic          err_o;

    always #4 clk = ~clk;

    baud_probe #(.CNT_W(CW), .BREAK_CYCLES(BC), .FILT_LEN(4)) dut_i (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .line_i  (line_i),
        .brk_o   (brk_o),
        .width_o (width_o),
        .div_o   (div_o),
        .done_o  (done_o),
        .err_o   (err_o)
    );

    typedef struct {
        logic  err;
        int    width;
        int    div;
        string tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_err = 0;
    int   n_push = 0;
    int   n_seen = 0;
    int   brk_run = 0;
    logic done_d = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic int exp_div(input int w);
        return (w < 4) ? 0 : (w - 4) / 8;
    endfunction

    // monitor: scoreboard pop on done, break length, done width
    always @(negedge clk) begin
        if (!rst) begin
            if (done_o) begin
                if (q.size() == 0) begin
                    check(1'b0, "R8", "done with no pending run", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(err_o == e.err, e.err ? "R3" : "R7", {e.tag, " err"},
                          int'(err_o), int'(e.err));
                    check(int'(width_o) == e.width, e.err ? "R3" : "R4", {e.tag, " width"},
                          int'(width_o), e.width);
                    check(int'(div_o) == e.div, e.err ? "R3" : "R5", {e.tag, " divisor"},
                          int'(div_o), e.div);
                end
                n_seen++;
            end
            if (done_o && done_d)
                check(1'b0, "R8", "done longer than one cycle", 2, 1);
            done_d = done_o;
            if (brk_o) begin
                brk_run++;
            end else if (brk_run > 0) begin
                check(brk_run == BC, "R2", "break length", brk_run, BC);
                brk_run = 0;
            end
        end
    end

    task automatic run_case(input int pre, input int hi, input bit glitch_lo,
                            input bit glitch_hi, input bit poke_start,
                            input bit exp_err, input string tag);
        exp_t e;
        logic [CW-1:0] w0, d0;
        logic          e0;
        e.err   = exp_err;
        e.width = exp_err ? 0 : hi;
        e.div   = exp_err ? 0 : exp_div(hi);
        e.tag   = tag;
        q.push_back(e);
        n_push++;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        // R8: accepted start clears the held results
        check(width_o == '0 && div_o == '0 && err_o == 1'b0, "R8",
              {tag, " cleared by start"}, int'(width_o), 0);
        check(brk_o == 1'b1, "R2", {tag, " break asserted"}, int'(brk_o), 1);
        while (brk_o) @(negedge clk);
        repeat (10) @(negedge clk);
        for (int i = 0; i < pre; i++) begin
            // R6: optional two-cycle high spike inside the low interval
            line_i  = glitch_lo && (i == pre / 2 || i == pre / 2 + 1);
            // R9: optional start pulse while busy
            start_i = poke_start && (i == pre / 2);
            @(negedge clk);
        end
        start_i = 1'b0;
        for (int i = 0; i < hi; i++) begin
            // R6: optional two-cycle low spike inside the high bit
            line_i = !(glitch_hi && (i == hi / 2 || i == hi / 2 + 1));
            @(negedge clk);
        end
        line_i = 1'b0;
        repeat (30) @(negedge clk);
        line_i = 1'b1;
        while (n_seen < n_push) @(negedge clk);
        w0 = width_o;
        d0 = div_o;
        e0 = err_o;
        repeat (20) @(negedge clk);
        // R8: results hold while idle
        check(width_o == w0 && div_o == d0 && err_o == e0, "R8",
              {tag, " hold after done"}, int'(width_o), int'(w0));
        check(brk_o == 1'b0, "R8", {tag, " idle after done"}, int'(brk_o), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(brk_o == 1'b0, "R1", "brk after reset", int'(brk_o), 0);
        check(done_o == 1'b0, "R1", "done after reset", int'(done_o), 0);
        check(err_o == 1'b0, "R1", "err after reset", int'(err_o), 0);
        check(width_o == '0, "R1", "width after reset", int'(width_o), 0);
        check(div_o == '0, "R1", "div after reset", int'(div_o), 0);

        // R4 / R5 / R7: plain measurements
        run_case(30, 100, 1'b0, 1'b0, 1'b0, 1'b0, "w100");
        run_case(30, 84, 1'b0, 1'b0, 1'b0, 1'b0, "w84");
        run_case(25, 12, 1'b0, 1'b0, 1'b0, 1'b0, "w12");
        // R5: smallest width that survives the filter gives divisor 0
        run_case(25, 4, 1'b0, 1'b0, 1'b0, 1'b0, "w4");
        run_case(30, 900, 1'b0, 1'b0, 1'b0, 1'b0, "w900");
        // R6: spikes rejected
        run_case(40, 37, 1'b1, 1'b0, 1'b0, 1'b0, "spike_low");
        run_case(30, 40, 1'b0, 1'b1, 1'b0, 1'b0, "spike_high");
        // R9: start while busy ignored
        run_case(40, 60, 1'b0, 1'b0, 1'b1, 1'b0, "busy_start");
        // R3: counter wraps before the rising edge, then before the falling edge
        run_case(1100, 20, 1'b0, 1'b0, 1'b0, 1'b1, "wrap_low");
        run_case(20, 1100, 1'b0, 1'b0, 1'b0, 1'b1, "wrap_high");
        // recovery after an error
        run_case(30, 52, 1'b0, 1'b0, 1'b0, 1'b0, "after_err");

        check(q.size() == 0, "R8", "all runs completed", q.size(), 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule